// File: doc/BRIEF.md
# Receive Frame Checksum Verifier

This block watches received Ethernet frames one byte per beat and checks them without changing them. Each frame starts at the first destination-address byte and ends on the beat marked last. In normal mode the block reads the 16-bit length/type word that follows the two 6-byte address fields. It accepts either a direct IPv4 type or a length value followed by a SNAP header. It then walks the IPv4 header, skipping any options. Along the way it builds two ones'-complement sums: one over the IPv4 header, and one over the TCP or UDP segment plus the pseudo-header.

One clock after the last beat, the block presents a status for one cycle. The status carries a parser-failure flag, an IP-header match flag, an L4-checked flag and an L4 match flag. A compatibility mode input turns format checking off. In that mode the block returns a raw ones'-complement sum over every byte after the 14-byte MAC header, and all the flags stay low.

The block sits beside the receive datapath. Frame bytes are never held or altered; only the status word is added.

Top module: `rxck_verifier`

## Requirements
- R1: The length/type word at byte offsets 12 (high byte) and 13 (low byte) decides the encapsulation. A value of 0x0800 places the IPv4 header at offset 14. A value below 0x05DC places the IPv4 header at offset 22, after an 8-byte SNAP header. Any other value is a parser failure.
- R2: When the SNAP path is taken, offsets 14 to 21 must hold AA AA 03 00 00 00 08 00. Any mismatching byte is a parser failure.
- R3: The first IPv4 byte must carry version 4 in bits 7:4 and a header length (IHL) of at least 5 in bits 3:0, or the frame is a parser failure. The IP match flag is set when the ones'-complement sum of all IHL×4 header bytes, options included, equals 0xFFFF.
- R4: The protocol byte at IP offset 9 selects TCP when it is 6 and UDP when it is 17; in both cases the L4-checked flag is set. Any other protocol leaves L4-checked and L4 match both low.
- R5: The L4 match flag is set when the L4 sum equals 0xFFFF. The L4 sum is taken over the pseudo-header (source IP, destination IP, a zero byte with the protocol, and L4 length = IP total length − IHL×4) and the segment bytes.
- R6: Sums use 16-bit big-endian words with end-around carry. A final odd byte is padded as the high byte of a word whose low byte is zero.
- R7: A UDP segment whose checksum field (L4 offsets 6 and 7) is zero is reported as an L4 match.
- R8: Bytes after the IP total length, such as Ethernet padding, do not enter the L4 sum.
- R9: A frame is a parser failure in any of these cases: it ends before the full IP header has arrived; for TCP or UDP, it ends before the IP total length is reached; or the total length is shorter than IHL×4 plus the L4 header (20 bytes for TCP, 8 for UDP, 0 for other protocols).
- R10: On a parser failure, IP match, L4-checked and L4 match are all low, and the frame passes through unchanged.
- R11: The mode input is sampled on the first byte of a frame. In compatibility mode no format check is made. The status gives the ones'-complement sum of every byte from offset 14 onward on `st_sum`, with all four flags low. In normal mode `st_sum` is zero.
- R12: `st_valid` is high for exactly one cycle, one clock after the beat that carries the last byte. All other status outputs are zero outside that cycle. Frames may follow each other with no idle beat.
- R13: After reset, `st_valid` is low and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 = compatibility mode (raw sum, no parsing); sampled on the first byte of a frame |
| in_valid | input | 1 | Byte beat present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| st_valid | output | 1 | Status valid for one cycle |
| st_parse_fail | output | 1 | Format check failed |
| st_ip_match | output | 1 | IPv4 header checksum matched |
| st_l4_checked | output | 1 | A TCP or UDP checksum was evaluated |
| st_l4_match | output | 1 | TCP/UDP checksum matched |
| st_sum | output | 16 | Compatibility-mode ones'-complement sum |

## Verification
The bench builds the block with MAX_FRAME_BYTES set to 512 and leaves the SNAP path and the zero-UDP-checksum pass enabled. With SNAP enabled, both encapsulations and the SNAP mismatch cases can be exercised. With the zero-checksum pass enabled, a UDP segment whose checksum field is zero is reported as a match. The 512-byte limit keeps the position counter narrow while covering every frame the bench builds, including IP options, odd-length segments, trailing padding and truncated datagrams. Frames are also sent back to back, which shows that the status pulse of one frame is unaffected by the first byte of the next.

// File: rtl/rxck_pkg.sv
package rxck_pkg;

   localparam logic [15:0] ETYPE_IPV4    = 16'h0800;
   localparam int          MAC_HDR_BYTES = 14;
   localparam int          SNAP_BYTES    = 8;
   localparam int          UDP_HDR_BYTES = 8;
   localparam int          TCP_HDR_BYTES = 20;
   localparam logic [7:0]  PROTO_TCP     = 8'd6;
   localparam logic [7:0]  PROTO_UDP     = 8'd17;

   typedef enum logic [1:0] {
      L4_NONE = 2'd0,
      L4_TCP  = 2'd1,
      L4_UDP  = 2'd2
   } l4_kind_e;

   // 16-bit ones'-complement addition with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   // expected SNAP header byte at index 0..7
   function automatic logic [7:0] snap_byte(input logic [2:0] idx);
      case (idx)
         3'd0, 3'd1: return 8'hAA;
         3'd2:       return 8'h03;
         3'd6:       return 8'h08;
         default:    return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rxck_ocsum.sv
module rxck_ocsum import rxck_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        beat,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] sum_o
);

   logic [15:0] acc_q, acc_b;
   logic [7:0]  hi_q;
   logic        have_q, have_b;

   always_comb begin
      acc_b  = clear ? 16'd0 : acc_q;
      have_b = clear ? 1'b0  : have_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         hi_q   <= '0;
         have_q <= 1'b0;
      end else if (beat) begin
         if (en) begin
            if (have_b) begin
               acc_q  <= oc_add(acc_b, {hi_q, din});
               have_q <= 1'b0;
            end else begin
               acc_q  <= acc_b;
               hi_q   <= din;
               have_q <= 1'b1;
            end
         end else begin
            acc_q  <= acc_b;
            have_q <= have_b;
         end
      end
   end

   // pending odd byte counts as high byte with zero low byte (R6)
   assign sum_o = have_q ? oc_add(acc_q, {hi_q, 8'h00}) : acc_q;

   a_r6_pair_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && en && !clear && have_q) |=> !have_q);
   a_r6_pair_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && en && (clear || !have_q)) |=> have_q);

endmodule

// File: rtl/rxck_parse.sv
module rxck_parse import rxck_pkg::*; #(
   parameter int          MAX_FRAME_BYTES = 2048,
   parameter bit          SNAP_EN         = 1'b1,
   parameter logic [15:0] TYPE_THRESH     = 16'h05DC
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   input  logic        compat_mode,
   output logic        beat_o,
   output logic        sof_o,
   output logic        hdr_en_o,
   output logic        l4_en_o,
   output logic        done_o,
   output logic        compat_o,
   output logic        fail_o,
   output l4_kind_e    kind_o,
   output logic [7:0]  proto_o,
   output logic [15:0] l4len_o,
   output logic [15:0] udp_ck_o
);

   localparam int          PW        = $clog2(MAX_FRAME_BYTES + 1);
   localparam logic [PW-1:0] CNT_MAX = PW'(MAX_FRAME_BYTES);
   localparam logic [16:0] BASE_V2   = 17'(MAC_HDR_BYTES);
   localparam logic [16:0] BASE_SNAP = 17'(MAC_HDR_BYTES + SNAP_BYTES);
   localparam logic [16:0] MAC_END   = 17'(MAC_HDR_BYTES);

   if (MAX_FRAME_BYTES < 64 || MAX_FRAME_BYTES > 65535) begin : g_bad_max
      $error("rxck_parse: MAX_FRAME_BYTES must lie in 64..65535");
   end
   if (TYPE_THRESH == 16'd0) begin : g_bad_thresh
      $error("rxck_parse: TYPE_THRESH must be non-zero");
   end

   // registered frame state
   logic          sof_q, done_q, compat_q, fail_q, base_ok_q, snap_q;
   logic [PW-1:0] cnt_q;
   logic [7:0]    lt_hi_q, tl_hi_q, proto_q, uck_hi_q, uck_lo_q;
   logic [3:0]    ihl_q;
   logic [15:0]   tl_q;

   // next state
   logic          compat_n, fail_n, base_ok_n, snap_n;
   logic [PW-1:0] cnt_n;
   logic [7:0]    lt_hi_n, tl_hi_n, proto_n, uck_hi_n, uck_lo_n;
   logic [3:0]    ihl_n;
   logic [15:0]   tl_n;

   // per-byte decode
   logic          snap_b, base_ok_b, in_ip, in_hdr, in_l4, snap_allow;
   logic [PW-1:0] cnt_b;
   logic [16:0]   pos, base, rel, hlen_cur, tl_cur, l4rel;
   logic [15:0]   lt_word;
   logic [2:0]    snap_idx;

   assign lt_word = {lt_hi_q, in_data};

   if (SNAP_EN) begin : g_snap
      assign snap_allow = (lt_word < TYPE_THRESH);
   end else begin : g_nosnap
      assign snap_allow = 1'b0;
   end

   always_comb begin
      compat_n  = sof_q ? compat_mode : compat_q;
      cnt_b     = sof_q ? '0 : cnt_q;
      fail_n    = sof_q ? 1'b0 : fail_q;
      base_ok_b = sof_q ? 1'b0 : base_ok_q;
      snap_b    = sof_q ? 1'b0 : snap_q;
      ihl_n     = sof_q ? 4'd0 : ihl_q;
      base_ok_n = base_ok_b;
      snap_n    = snap_b;
      lt_hi_n   = lt_hi_q;
      tl_hi_n   = tl_hi_q;
      tl_n      = tl_q;
      proto_n   = proto_q;
      uck_hi_n  = uck_hi_q;
      uck_lo_n  = uck_lo_q;
      cnt_n     = (cnt_b == CNT_MAX) ? cnt_b : cnt_b + PW'(1);

      pos      = 17'(cnt_b);
      base     = snap_b ? BASE_SNAP : BASE_V2;
      in_ip    = base_ok_b && (pos >= base);
      rel      = pos - base;
      hlen_cur = {11'd0, ihl_q, 2'b00};
      tl_cur   = {1'b0, tl_q};
      in_hdr   = in_ip && ((rel == 17'd0) || (rel < hlen_cur));
      in_l4    = in_ip && (rel >= 17'd20) && (rel >= hlen_cur) && (rel < tl_cur);
      l4rel    = rel - hlen_cur;
      snap_idx = 3'(pos - MAC_END);

      // encapsulation (R1, R2)
      if (pos == 17'd12) lt_hi_n = in_data;
      if (pos == 17'd13) begin
         if (lt_word == ETYPE_IPV4) begin
            base_ok_n = 1'b1;
         end else if (snap_allow) begin
            base_ok_n = 1'b1;
            snap_n    = 1'b1;
         end else begin
            fail_n = 1'b1;
         end
      end
      if (snap_b && pos >= MAC_END && pos < BASE_SNAP && in_data != snap_byte(snap_idx))
         fail_n = 1'b1;

      // IPv4 header fields (R3, R4)
      if (in_ip) begin
         case (rel)
            17'd0: begin
               ihl_n = in_data[3:0];
               if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) fail_n = 1'b1;
            end
            17'd2: tl_hi_n = in_data;
            17'd3: tl_n    = {tl_hi_q, in_data};
            17'd9: proto_n = in_data;
            default: ;
         endcase
      end

      // UDP checksum field capture (R7)
      if (in_l4 && proto_q == PROTO_UDP) begin
         if (l4rel == 17'd6) uck_hi_n = in_data;
         if (l4rel == 17'd7) uck_lo_n = in_data;
      end
   end

   assign beat_o   = in_valid;
   assign sof_o    = sof_q;
   assign hdr_en_o = compat_n ? (pos >= MAC_END) : in_hdr;
   assign l4_en_o  = !compat_n && in_ip &&
                     (((rel >= 17'd12) && (rel < 17'd20)) || in_l4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sof_q     <= 1'b1;
         done_q    <= 1'b0;
         compat_q  <= 1'b0;
         fail_q    <= 1'b0;
         base_ok_q <= 1'b0;
         snap_q    <= 1'b0;
         cnt_q     <= '0;
         lt_hi_q   <= '0;
         tl_hi_q   <= '0;
         proto_q   <= '0;
         uck_hi_q  <= '0;
         uck_lo_q  <= '0;
         ihl_q     <= '0;
         tl_q      <= '0;
      end else begin
         done_q <= in_valid && in_last;
         if (in_valid) begin
            sof_q     <= in_last;
            compat_q  <= compat_n;
            fail_q    <= fail_n;
            base_ok_q <= base_ok_n;
            snap_q    <= snap_n;
            cnt_q     <= cnt_n;
            lt_hi_q   <= lt_hi_n;
            tl_hi_q   <= tl_hi_n;
            proto_q   <= proto_n;
            uck_hi_q  <= uck_hi_n;
            uck_lo_q  <= uck_lo_n;
            ihl_q     <= ihl_n;
            tl_q      <= tl_n;
         end
      end
   end

   // end-of-frame evaluation from held state (R9)
   logic [16:0] hlen_q, tl_q17, need, min_l4, base_q, got;
   always_comb begin
      if (proto_q == PROTO_TCP)      kind_o = L4_TCP;
      else if (proto_q == PROTO_UDP) kind_o = L4_UDP;
      else                           kind_o = L4_NONE;
      hlen_q = {11'd0, ihl_q, 2'b00};
      tl_q17 = {1'b0, tl_q};
      base_q = snap_q ? BASE_SNAP : BASE_V2;
      got    = 17'(cnt_q);
      case (kind_o)
         L4_TCP:  min_l4 = 17'(TCP_HDR_BYTES);
         L4_UDP:  min_l4 = 17'(UDP_HDR_BYTES);
         default: min_l4 = 17'd0;
      endcase
      need   = (kind_o != L4_NONE) ? tl_q17 : hlen_q;
      fail_o = !compat_q && (fail_q || !base_ok_q || (hlen_q < 17'd20) ||
                             (got < base_q + need) || (tl_q17 < hlen_q + min_l4));
   end

   assign done_o   = done_q;
   assign compat_o = compat_q;
   assign proto_o  = proto_q;
   assign l4len_o  = tl_q - {10'd0, ihl_q, 2'b00};
   assign udp_ck_o = {uck_hi_q, uck_lo_q};

   a_r12_status_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> done_q);
   a_r12_status_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(in_valid && in_last));
   a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sof_q && fail_q) |=> fail_q);
   a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !sof_q) |=> $stable(compat_q));

endmodule

// File: rtl/rxck_verifier.sv
module rxck_verifier import rxck_pkg::*; #(
   parameter int          MAX_FRAME_BYTES = 2048,
   parameter bit          SNAP_EN         = 1'b1,
   parameter bit          UDP_ZERO_PASS   = 1'b1,
   parameter logic [15:0] TYPE_THRESH     = 16'h05DC
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        compat_mode,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   output logic        st_valid,
   output logic        st_parse_fail,
   output logic        st_ip_match,
   output logic        st_l4_checked,
   output logic        st_l4_match,
   output logic [15:0] st_sum
);

   logic        beat, sof, hdr_en, l4_en, done, compat, fail;
   l4_kind_e    kind;
   logic [7:0]  proto;
   logic [15:0] l4len, udp_ck, hdr_sum, l4_sum, l4_total;
   logic        udp_zero_ok, good;

   rxck_parse #(
      .MAX_FRAME_BYTES (MAX_FRAME_BYTES),
      .SNAP_EN         (SNAP_EN),
      .TYPE_THRESH     (TYPE_THRESH)
   ) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_last     (in_last),
      .compat_mode (compat_mode),
      .beat_o      (beat),
      .sof_o       (sof),
      .hdr_en_o    (hdr_en),
      .l4_en_o     (l4_en),
      .done_o      (done),
      .compat_o    (compat),
      .fail_o      (fail),
      .kind_o      (kind),
      .proto_o     (proto),
      .l4len_o     (l4len),
      .udp_ck_o    (udp_ck)
   );

   // header sum in normal mode, raw post-MAC sum in compatibility mode
   rxck_ocsum u_hdr_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .beat  (beat),
      .clear (sof),
      .en    (hdr_en),
      .din   (in_data),
      .sum_o (hdr_sum)
   );

   // pseudo-header addresses plus L4 segment
   rxck_ocsum u_l4_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .beat  (beat),
      .clear (sof),
      .en    (l4_en),
      .din   (in_data),
      .sum_o (l4_sum)
   );

   assign l4_total = oc_add(oc_add(l4_sum, {8'd0, proto}), l4len);

   if (UDP_ZERO_PASS) begin : g_udp_zero
      assign udp_zero_ok = (kind == L4_UDP) && (udp_ck == 16'd0);
   end else begin : g_udp_strict
      assign udp_zero_ok = 1'b0;
   end

   assign good          = done && !compat && !fail;
   assign st_valid      = done;
   assign st_parse_fail = done && fail;
   assign st_ip_match   = good && (hdr_sum == 16'hFFFF);
   assign st_l4_checked = good && (kind != L4_NONE);
   assign st_l4_match   = st_l4_checked && ((l4_total == 16'hFFFF) || udp_zero_ok);
   assign st_sum        = (done && compat) ? hdr_sum : 16'd0;

   a_r4_match_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
      st_l4_match |-> st_l4_checked);
   a_r10_fail_masks: assert property (@(posedge clk) disable iff (!rst_n)
      st_parse_fail |-> (!st_ip_match && !st_l4_checked && !st_l4_match));
   a_r12_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> (!st_parse_fail && !st_ip_match && !st_l4_checked && st_sum == 16'd0));
   a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !(in_valid && in_last)) |=> !st_valid);
   a_r11_compat_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sum != 16'd0) |-> (!st_parse_fail && !st_ip_match && !st_l4_checked));

endmodule

// File: tb/sim_rxck_verifier.sv
module sim_rxck_verifier;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        compat_mode = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_last = 1'b0;
   logic        st_valid, st_parse_fail, st_ip_match, st_l4_checked, st_l4_match;
   logic [15:0] st_sum;

   int n_run = 0;
   int n_fail = 0;

   logic [7:0] fr [0:511];
   int flen, ipb, l4b;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxck_verifier #(.MAX_FRAME_BYTES(512)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .compat_mode   (compat_mode),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .in_last       (in_last),
      .st_valid      (st_valid),
      .st_parse_fail (st_parse_fail),
      .st_ip_match   (st_ip_match),
      .st_l4_checked (st_l4_checked),
      .st_l4_match   (st_l4_match),
      .st_sum        (st_sum)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference ones'-complement sum of fr[a..b-1], odd tail padded low
   function automatic logic [15:0] bsum(input int a, input int b);
      logic [31:0] s = 0;
      for (int i = a; i < b; i += 2)
         s += 32'({fr[i], ((i + 1 < b) ? fr[i+1] : 8'h00)});
      while (s[31:16] != 0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
      return s[15:0];
   endfunction

   function automatic logic [15:0] fold_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   task automatic build(input bit snap, input int ihl, input logic [7:0] proto,
                        input int dlen, input int pad);
      int h, hl4, l4len, tl;
      logic [15:0] c;
      for (int i = 0; i < 12; i++) fr[i] = 8'h10 + 8'(i);
      h = ihl * 4;
      hl4 = (proto == 8'd6) ? 20 : (proto == 8'd17) ? 8 : 0;
      l4len = hl4 + dlen;
      tl = h + l4len;
      if (snap) begin
         fr[12] = 8'(((tl + 8) >> 8)); fr[13] = 8'(tl + 8);
         fr[14] = 8'hAA; fr[15] = 8'hAA; fr[16] = 8'h03; fr[17] = 8'h00;
         fr[18] = 8'h00; fr[19] = 8'h00; fr[20] = 8'h08; fr[21] = 8'h00;
         ipb = 22;
      end else begin
         fr[12] = 8'h08; fr[13] = 8'h00;
         ipb = 14;
      end
      fr[ipb]    = {4'd4, 4'(ihl)};
      fr[ipb+1]  = 8'h00;
      fr[ipb+2]  = 8'(tl >> 8);
      fr[ipb+3]  = 8'(tl);
      fr[ipb+4]  = 8'h12; fr[ipb+5] = 8'h34; fr[ipb+6] = 8'h40; fr[ipb+7] = 8'h00;
      fr[ipb+8]  = 8'h40;
      fr[ipb+9]  = proto;
      fr[ipb+10] = 8'h00; fr[ipb+11] = 8'h00;
      fr[ipb+12] = 8'hC0; fr[ipb+13] = 8'hA8; fr[ipb+14] = 8'h01; fr[ipb+15] = 8'h0A;
      fr[ipb+16] = 8'h0A; fr[ipb+17] = 8'h00; fr[ipb+18] = 8'h00; fr[ipb+19] = 8'h07;
      for (int i = 20; i < h; i++) fr[ipb+i] = 8'h01;
      l4b = ipb + h;
      for (int i = 0; i < l4len; i++) fr[l4b+i] = 8'(i * 7 + 3);
      if (proto == 8'd17) begin
         fr[l4b+4] = 8'(l4len >> 8); fr[l4b+5] = 8'(l4len);
         fr[l4b+6] = 8'h00; fr[l4b+7] = 8'h00;
      end else if (proto == 8'd6) begin
         fr[l4b+12] = 8'h50;
         fr[l4b+16] = 8'h00; fr[l4b+17] = 8'h00;
      end
      c = ~bsum(ipb, ipb + h);
      fr[ipb+10] = c[15:8]; fr[ipb+11] = c[7:0];
      if (hl4 != 0) begin
         c = fold_add(bsum(ipb + 12, ipb + 20), {8'd0, proto});
         c = fold_add(c, 16'(l4len));
         c = ~fold_add(c, bsum(l4b, l4b + l4len));
         if (proto == 8'd17) begin
            if (c == 16'd0) c = 16'hFFFF;
            fr[l4b+6] = c[15:8]; fr[l4b+7] = c[7:0];
         end else begin
            fr[l4b+16] = c[15:8]; fr[l4b+17] = c[7:0];
         end
      end
      flen = l4b + l4len + pad;
      for (int i = l4b + l4len; i < flen; i++) fr[i] = 8'hA5;
   endtask

   task automatic drive_byte(input int i, input bit last, input bit cmp);
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = last; compat_mode = cmp;
   endtask

   // send fr[0..flen-1]; returns at the negedge where status is expected
   task automatic send(input bit cmp);
      for (int i = 0; i < flen; i++) drive_byte(i, i == flen - 1, cmp);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic expect_st(input string tag, input bit pf, input bit ipm,
                            input bit l4c, input bit l4m, input logic [15:0] sm);
      chk({tag, " valid"}, 32'(st_valid), 1);
      chk({tag, " parse_fail"}, 32'(st_parse_fail), 32'(pf));
      chk({tag, " ip_match"}, 32'(st_ip_match), 32'(ipm));
      chk({tag, " l4_checked"}, 32'(st_l4_checked), 32'(l4c));
      chk({tag, " l4_match"}, 32'(st_l4_match), 32'(l4m));
      chk({tag, " sum"}, 32'(st_sum), 32'(sm));
   endtask

   task automatic t_reset();
      chk("R13 reset valid", 32'(st_valid), 0);
      chk("R13 reset flags", 32'({st_parse_fail, st_ip_match, st_l4_checked, st_l4_match}), 0);
   endtask

   task automatic t_v2_udp();
      build(1'b0, 5, 8'd17, 12, 0);
      send(1'b0);
      expect_st("R1 R5 v2 udp", 0, 1, 1, 1, 16'h0);
      @(negedge clk);
      chk("R12 pulse ends", 32'(st_valid), 0);
   endtask

   task automatic t_snap_tcp_odd();
      build(1'b1, 5, 8'd6, 13, 0);
      send(1'b0);
      expect_st("R1 R6 snap tcp odd", 0, 1, 1, 1, 16'h0);
   endtask

   task automatic t_snap_bad();
      build(1'b1, 5, 8'd17, 6, 0);
      fr[16] = 8'h04;
      send(1'b0);
      expect_st("R2 R10 snap mismatch", 1, 0, 0, 0, 16'h0);
   endtask

   task automatic t_bad_type();
      build(1'b0, 5, 8'd17, 6, 0);
      fr[12] = 8'h86; fr[13] = 8'hDD;
      send(1'b0);
      expect_st("R1 type not ipv4", 1, 0, 0, 0, 16'h0);
   endtask

   task automatic t_ip_bad_sum();
      build(1'b0, 5, 8'd17, 10, 0);
      fr[ipb+8] = fr[ipb+8] ^ 8'h01;
      send(1'b0);
      expect_st("R3 ip header mismatch", 0, 0, 1, 1, 16'h0);
   endtask

   task automatic t_ip_options();
      build(1'b0, 7, 8'd6, 9, 0);
      send(1'b0);
      expect_st("R3 ip options", 0, 1, 1, 1, 16'h0);
   endtask

   task automatic t_bad_version();
      build(1'b0, 5, 8'd17, 4, 0);
      fr[ipb] = 8'h65;
      send(1'b0);
      expect_st("R3 version 6", 1, 0, 0, 0, 16'h0);
      build(1'b0, 5, 8'd17, 4, 0);
      fr[ipb] = 8'h44;
      send(1'b0);
      expect_st("R3 ihl 4", 1, 0, 0, 0, 16'h0);
   endtask

   task automatic t_l4_bad();
      build(1'b0, 5, 8'd6, 16, 0);
      fr[l4b+25] = fr[l4b+25] ^ 8'h40;
      send(1'b0);
      expect_st("R5 tcp payload corrupt", 0, 1, 1, 0, 16'h0);
   endtask

   task automatic t_udp_zero();
      build(1'b0, 5, 8'd17, 11, 0);
      fr[l4b+6] = 8'h00; fr[l4b+7] = 8'h00;
      send(1'b0);
      expect_st("R7 udp zero checksum", 0, 1, 1, 1, 16'h0);
   endtask

   task automatic t_other_proto();
      build(1'b0, 5, 8'd1, 12, 0);
      send(1'b0);
      expect_st("R4 protocol 1", 0, 1, 0, 0, 16'h0);
   endtask

   task automatic t_padding();
      build(1'b0, 5, 8'd17, 4, 14);
      send(1'b0);
      expect_st("R8 ethernet padding", 0, 1, 1, 1, 16'h0);
   endtask

   task automatic t_trunc();
      build(1'b0, 5, 8'd6, 10, 0);
      flen = flen - 5;
      send(1'b0);
      expect_st("R9 truncated segment", 1, 0, 0, 0, 16'h0);
      build(1'b0, 5, 8'd6, 10, 0);
      flen = ipb + 12;
      send(1'b0);
      expect_st("R9 truncated ip header", 1, 0, 0, 0, 16'h0);
      build(1'b0, 5, 8'd6, 10, 0);
      fr[ipb+3] = 8'(20 + 10);
      send(1'b0);
      expect_st("R9 total length below tcp header", 1, 0, 0, 0, 16'h0);
   endtask

   task automatic t_compat();
      logic [15:0] e;
      build(1'b0, 5, 8'd17, 9, 0);
      e = bsum(14, flen);
      send(1'b1);
      expect_st("R11 compat udp frame", 0, 0, 0, 0, e);
      flen = 33;
      for (int i = 0; i < flen; i++) fr[i] = 8'(i * 13 + 5);
      e = bsum(14, flen);
      send(1'b1);
      expect_st("R11 R6 compat odd raw", 0, 0, 0, 0, e);
   endtask

   task automatic t_back_to_back();
      logic [7:0] fa [0:511];
      int la;
      build(1'b0, 5, 8'd17, 8, 0);
      for (int i = 0; i < flen; i++) fa[i] = fr[i];
      la = flen;
      build(1'b1, 5, 8'd6, 7, 0);
      fr[l4b+22] = fr[l4b+22] ^ 8'h11;
      for (int i = 0; i < la; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = fa[i]; in_last = (i == la - 1); compat_mode = 1'b0;
      end
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         if (i == 0) expect_st("R12 back-to-back first", 0, 1, 1, 1, 16'h0);
         if (i == 1) chk("R12 back-to-back single pulse", 32'(st_valid), 0);
         in_valid = 1'b1; in_data = fr[i]; in_last = (i == flen - 1);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      expect_st("R12 back-to-back second", 0, 1, 1, 0, 16'h0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_v2_udp();
      t_snap_tcp_odd();
      t_snap_bad();
      t_bad_type();
      t_ip_bad_sum();
      t_ip_options();
      t_bad_version();
      t_l4_bad();
      t_udp_zero();
      t_other_proto();
      t_padding();
      t_trunc();
      t_compat();
      t_back_to_back();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule